// File: doc/BRIEF.md
# Register Vector-Attribute Lookup Unit

This unit sits in the decode stage. For each register operand of an instruction it decides whether the operand is a plain scalar or a vector, and it reports the operand's element count and packed element width. The decoder presents up to three register numbers (operand 0 is the destination, operands 1 and 2 are sources), a use bit per operand and one file-select bit choosing the integer or the floating-point register file. The unit answers in the same cycle with per-operand attributes and with a classification of the whole instruction: pass-through (behaves as if no vector support existed), vector-sequenced, packed, or both. It also raises a length fault when the operand lengths cannot be reconciled.

The configuration consists of one marking bitmap per register file, with one bit per register, and a small table of tagged entries. Each entry holds a valid bit, a file bit, a register number, a length and a width code. A marked operand takes its length and width from the first matching entry. A marked operand with no matching entry, and any unmarked operand, are treated as scalar at the default width. The configuration is written through a single write port and changes what later instructions see, starting on the cycle after the write.

Top module: `vattr_lookup`

## Requirements
- R1: After reset both bitmaps are clear and all table entries are invalid, so every operand reports length 1, width code 0 and vector flag 0, and the instruction is pass-through.
- R2: An operand's vector flag equals the bit for its register number in the bitmap of the selected file (file bit 0 = integer, 1 = floating point), provided its use bit is set.
- R3: A marked operand takes its length and width code from the lowest-numbered valid entry whose file bit and register number match. Width codes are 0 = full word (default), 1 = 8-bit, 2 = 16-bit and 3 = 32-bit.
- R4: A marked operand with no matching entry, and any unmarked operand even when an entry matches it, reports length 1 and width code 0.
- R5: An entry whose file bit differs from the instruction's file bit never matches, even if the register number is equal.
- R6: The pass-through flag is 1 exactly when every used operand has length 1 and width code 0.
- R7: The vector flag is 1 when any used operand has length above 1. The packed flag is 1 when any used operand has a non-zero width code. Both may be 1 together.
- R8: The length fault is 1 when two used source operands both have length above 1 and their lengths differ.
- R9: The length fault is 1 when the used destination has length above 1 and a used source is longer than it.
- R10: An operand whose use bit is 0 reports length 1, width code 0 and flag 0, and does not affect the mode flags or the fault.
- R11: A write with kind 0 loads the integer bitmap and kind 1 loads the floating-point bitmap, both from data bits [NREG-1:0]. Kind 2 loads the entry selected by the entry index from data bit 31 (valid), bit 30 (file), bits [20:16] (register), bits [9:8] (width code) and bits [7:0] (length). A write is first visible to a lookup in the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Configuration write strobe |
| csr_kind | input | 2 | Write target: 0 integer bitmap, 1 FP bitmap, 2 table entry |
| csr_entry | input | ENT_IDX_W | Table entry index for kind 2 |
| csr_wdata | input | 32 | Write data |
| op_file | input | 1 | Register file of the instruction: 0 integer, 1 FP |
| op_use | input | NOPS | Per-operand use bits; operand 0 is the destination |
| op_reg | input | NOPS*REG_W | Per-operand register numbers |
| op_len | output | NOPS*LEN_W | Per-operand element count |
| op_bw | output | NOPS*2 | Per-operand width code |
| op_vec | output | NOPS | Per-operand vector flag |
| mode_passthru | output | 1 | Instruction needs no vector or packed handling |
| mode_vector | output | 1 | Instruction needs vector sequencing |
| mode_packed | output | 1 | Instruction needs packed-width handling |
| len_fault | output | 1 | Operand lengths are inconsistent |

## Verification
The bench sweeps every combination of destination, sources and use mask over a group of registers, under several table setups, and compares each result with a model built from the requirements. A design that let the later entry win when two entries name the same register, or that ignored the file bit, would report the wrong length for those registers. If the table were applied to unmarked registers, scalars would turn into vectors. Faults are checked for equal lengths, for unequal lengths, for a shorter vector destination and for a scalar destination with vector sources. A design that got the fault logic wrong would either flag legal reductions or miss mismatches, and unused operands that were not masked would leak their length into the mode flags. A write is probed both before and after the edge that captures it, which catches a lookup that bypasses the registers or lags one cycle too far.

// File: rtl/vattr_pkg.sv
`timescale 1ns/1ps
package vattr_pkg;
    typedef enum logic [1:0] {
        CSR_IMAP  = 2'd0,
        CSR_FMAP  = 2'd1,
        CSR_ENTRY = 2'd2
    } csr_kind_e;

    // Field positions of a table entry inside the 32-bit write data.
    localparam int WD_VALID_BIT = 31;
    localparam int WD_FILE_BIT  = 30;
    localparam int WD_REG_LSB   = 16;
    localparam int WD_BW_LSB    = 8;
    localparam int WD_LEN_LSB   = 0;

    localparam logic [1:0] BW_DEFAULT = 2'd0;
endpackage

// File: rtl/vattr_cfg_regs.sv
`timescale 1ns/1ps
module vattr_cfg_regs
    import vattr_pkg::*;
#(
    parameter int NREG      = 32,
    parameter int NENT      = 2,
    parameter int REG_W     = 5,
    parameter int LEN_W     = 8,
    parameter int ENT_IDX_W = 1,
    localparam int ENT_W    = 2 + REG_W + 2 + LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_we,
    input  logic [1:0]              csr_kind,
    input  logic [ENT_IDX_W-1:0]    csr_entry,
    input  logic [31:0]             csr_wdata,
    output logic [NREG-1:0]         imap_o,
    output logic [NREG-1:0]         fmap_o,
    output logic [NENT*ENT_W-1:0]   tab_o
);
    typedef struct packed {
        logic [NREG-1:0]       imap;
        logic [NREG-1:0]       fmap;
        logic [NENT*ENT_W-1:0] tab;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [ENT_W-1:0] new_ent;

    always_comb begin
        new_ent = {csr_wdata[WD_VALID_BIT], csr_wdata[WD_FILE_BIT],
                   csr_wdata[WD_REG_LSB +: REG_W], csr_wdata[WD_BW_LSB +: 2],
                   csr_wdata[WD_LEN_LSB +: LEN_W]};
        cfg_d = cfg_q;
        if (csr_we) begin
            case (csr_kind)
                CSR_IMAP: cfg_d.imap = csr_wdata[NREG-1:0];
                CSR_FMAP: cfg_d.fmap = csr_wdata[NREG-1:0];
                CSR_ENTRY: begin
                    for (int e = 0; e < NENT; e++) begin
                        if (csr_entry == ENT_IDX_W'(e))
                            cfg_d.tab[e*ENT_W +: ENT_W] = new_ent;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign imap_o = cfg_q.imap;
    assign fmap_o = cfg_q.fmap;
    assign tab_o  = cfg_q.tab;

    assert_imap_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_kind == CSR_IMAP) |=> imap_o == $past(csr_wdata[NREG-1:0]));
    assert_fmap_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_kind == CSR_FMAP) |=> fmap_o == $past(csr_wdata[NREG-1:0]));
    assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(cfg_q));
endmodule

// File: rtl/vattr_operand_resolve.sv
`timescale 1ns/1ps
module vattr_operand_resolve
    import vattr_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int NENT   = 2,
    parameter int REG_W  = 5,
    parameter int LEN_W  = 8,
    localparam int ENT_W = 2 + REG_W + 2 + LEN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_use,
    input  logic                  op_file,
    input  logic [REG_W-1:0]      op_reg,
    input  logic [NREG-1:0]       imap,
    input  logic [NREG-1:0]       fmap,
    input  logic [NENT*ENT_W-1:0] tab,
    output logic [LEN_W-1:0]      len_o,
    output logic [1:0]            bw_o,
    output logic                  vec_o
);
    logic             marked;
    logic             hit;
    logic [ENT_W-1:0] ent;

    always_comb begin
        marked = op_file ? fmap[op_reg] : imap[op_reg];
        hit    = 1'b0;
        len_o  = LEN_W'(1);
        bw_o   = BW_DEFAULT;
        ent    = '0;
        // Lowest index wins: later entries are skipped once one has hit.
        for (int e = 0; e < NENT; e++) begin
            ent = tab[e*ENT_W +: ENT_W];
            if (!hit && ent[ENT_W-1] && (ent[ENT_W-2] == op_file) &&
                (ent[LEN_W+2 +: REG_W] == op_reg)) begin
                hit   = 1'b1;
                len_o = ent[LEN_W-1:0];
                bw_o  = ent[LEN_W +: 2];
            end
        end
        if (!(op_use && marked)) begin
            len_o = LEN_W'(1);
            bw_o  = BW_DEFAULT;
        end
        vec_o = op_use && marked;
    end

    assert_unmarked_scalar_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_o |-> (len_o == LEN_W'(1) && bw_o == BW_DEFAULT));
endmodule

// File: rtl/vattr_classify.sv
`timescale 1ns/1ps
module vattr_classify
    import vattr_pkg::*;
#(
    parameter int NOPS  = 3,
    parameter int LEN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NOPS-1:0]       op_use,
    input  logic [NOPS*LEN_W-1:0] lens,
    input  logic [NOPS*2-1:0]     bws,
    output logic                  passthru_o,
    output logic                  vector_o,
    output logic                  packed_o,
    output logic                  fault_o
);
    logic [LEN_W-1:0] li, lj, ld;

    always_comb begin
        vector_o = 1'b0;
        packed_o = 1'b0;
        fault_o  = 1'b0;
        li = '0;
        lj = '0;
        ld = lens[LEN_W-1:0];
        for (int i = 0; i < NOPS; i++) begin
            li = lens[i*LEN_W +: LEN_W];
            if (op_use[i] && li > LEN_W'(1))       vector_o = 1'b1;
            if (op_use[i] && bws[i*2 +: 2] != BW_DEFAULT) packed_o = 1'b1;
        end
        // Source pairs: both vectors must agree on length.
        for (int i = 1; i < NOPS; i++) begin
            for (int j = i + 1; j < NOPS; j++) begin
                li = lens[i*LEN_W +: LEN_W];
                lj = lens[j*LEN_W +: LEN_W];
                if (op_use[i] && op_use[j] && li > LEN_W'(1) &&
                    lj > LEN_W'(1) && li != lj)
                    fault_o = 1'b1;
            end
        end
        // Vector destination must be at least as long as every source.
        if (op_use[0] && ld > LEN_W'(1)) begin
            for (int i = 1; i < NOPS; i++) begin
                li = lens[i*LEN_W +: LEN_W];
                if (op_use[i] && li > ld) fault_o = 1'b1;
            end
        end
        passthru_o = !vector_o && !packed_o;
    end

    assert_fault_implies_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> vector_o);
    assert_passthru_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({passthru_o, vector_o || packed_o}) == 1);
endmodule

// File: rtl/vattr_lookup.sv
`timescale 1ns/1ps
module vattr_lookup
    import vattr_pkg::*;
#(
    parameter int NREG       = 32,
    parameter int NENT       = 2,
    parameter int NOPS       = 3,
    localparam int REG_W     = $clog2(NREG),
    localparam int LEN_W     = (NREG <= 16) ? 7 : 8,
    localparam int ENT_IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_we,
    input  logic [1:0]            csr_kind,
    input  logic [ENT_IDX_W-1:0]  csr_entry,
    input  logic [31:0]           csr_wdata,
    input  logic                  op_file,
    input  logic [NOPS-1:0]       op_use,
    input  logic [NOPS*REG_W-1:0] op_reg,
    output logic [NOPS*LEN_W-1:0] op_len,
    output logic [NOPS*2-1:0]     op_bw,
    output logic [NOPS-1:0]       op_vec,
    output logic                  mode_passthru,
    output logic                  mode_vector,
    output logic                  mode_packed,
    output logic                  len_fault
);
    localparam int ENT_W = 2 + REG_W + 2 + LEN_W;

    logic [NREG-1:0]       imap, fmap;
    logic [NENT*ENT_W-1:0] tab;

    vattr_cfg_regs #(
        .NREG(NREG), .NENT(NENT), .REG_W(REG_W), .LEN_W(LEN_W), .ENT_IDX_W(ENT_IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_kind(csr_kind),
        .csr_entry(csr_entry), .csr_wdata(csr_wdata),
        .imap_o(imap), .fmap_o(fmap), .tab_o(tab)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        vattr_operand_resolve #(
            .NREG(NREG), .NENT(NENT), .REG_W(REG_W), .LEN_W(LEN_W)
        ) u_res (
            .clk(clk), .rst_n(rst_n), .op_use(op_use[g]), .op_file(op_file),
            .op_reg(op_reg[g*REG_W +: REG_W]), .imap(imap), .fmap(fmap), .tab(tab),
            .len_o(op_len[g*LEN_W +: LEN_W]), .bw_o(op_bw[g*2 +: 2]), .vec_o(op_vec[g])
        );

        assert_unused_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !op_use[g] |-> (op_len[g*LEN_W +: LEN_W] == LEN_W'(1) &&
                            op_bw[g*2 +: 2] == BW_DEFAULT && !op_vec[g]));
    end

    vattr_classify #(.NOPS(NOPS), .LEN_W(LEN_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .op_use(op_use), .lens(op_len), .bws(op_bw),
        .passthru_o(mode_passthru), .vector_o(mode_vector),
        .packed_o(mode_packed), .fault_o(len_fault)
    );

    logic all_scalar_default;
    always_comb begin
        all_scalar_default = 1'b1;
        for (int i = 0; i < NOPS; i++)
            if (op_len[i*LEN_W +: LEN_W] != LEN_W'(1) || op_bw[i*2 +: 2] != BW_DEFAULT)
                all_scalar_default = 1'b0;
    end

    assert_passthru_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_passthru |-> all_scalar_default);
    assert_long_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_vector |-> !len_fault);
endmodule

// File: tb/vattr_lookup_tb_top.sv
`timescale 1ns/1ps
module vattr_lookup_tb_top;
    localparam int NREG = 32, NENT = 2, NOPS = 3, REG_W = 5, LEN_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic csr_we = 1'b0;
    logic [1:0] csr_kind = '0;
    logic [0:0] csr_entry = '0;
    logic [31:0] csr_wdata = '0;
    logic op_file = 1'b0;
    logic [NOPS-1:0] op_use = '0;
    logic [NOPS*REG_W-1:0] op_reg = '0;
    logic [NOPS*LEN_W-1:0] op_len;
    logic [NOPS*2-1:0] op_bw;
    logic [NOPS-1:0] op_vec;
    logic mode_passthru, mode_vector, mode_packed, len_fault;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Requirement-level model of the configuration.
    bit [31:0] m_imap = '0, m_fmap = '0;
    bit m_ev[NENT], m_ef[NENT];
    int m_er[NENT], m_eb[NENT], m_el[NENT];

    always #2 clk = ~clk;

    vattr_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_kind(csr_kind),
        .csr_entry(csr_entry), .csr_wdata(csr_wdata), .op_file(op_file),
        .op_use(op_use), .op_reg(op_reg), .op_len(op_len), .op_bw(op_bw),
        .op_vec(op_vec), .mode_passthru(mode_passthru), .mode_vector(mode_vector),
        .mode_packed(mode_packed), .len_fault(len_fault)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit m_mark(bit f, int r);
        return f ? m_fmap[r] : m_imap[r];
    endfunction

    function automatic int m_len(bit f, int r);
        if (!m_mark(f, r)) return 1;
        for (int e = 0; e < NENT; e++)
            if (m_ev[e] && m_ef[e] == f && m_er[e] == r) return m_el[e];
        return 1;
    endfunction

    function automatic int m_bw(bit f, int r);
        if (!m_mark(f, r)) return 0;
        for (int e = 0; e < NENT; e++)
            if (m_ev[e] && m_ef[e] == f && m_er[e] == r) return m_eb[e];
        return 0;
    endfunction

    task automatic csr_write(int kind, int idx, logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_kind = kind[1:0]; csr_entry = idx[0:0]; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic wr_map(bit f, logic [31:0] v);
        csr_write(f ? 1 : 0, 0, v);
        if (f) m_fmap = v; else m_imap = v;
    endtask

    task automatic wr_ent(int e, bit v, bit f, int r, int bw, int len);
        logic [31:0] d;
        d = '0;
        d[31] = v; d[30] = f; d[20:16] = r[4:0]; d[9:8] = bw[1:0]; d[7:0] = len[7:0];
        csr_write(2, e, d);
        m_ev[e] = v; m_ef[e] = f; m_er[e] = r; m_eb[e] = bw; m_el[e] = len;
    endtask

    // One lookup, checked against the model in the low clock phase.
    task automatic look(bit f, logic [2:0] use_m, int d, int s1, int s2, string req);
        int r[3], el[3], eb[3];
        bit ev[3], any_long, any_pk, flt;
        r[0] = d; r[1] = s1; r[2] = s2;
        @(negedge clk);
        op_file = f; op_use = use_m;
        op_reg = {s2[4:0], s1[4:0], d[4:0]};
        #1;
        any_long = 0; any_pk = 0; flt = 0;
        for (int i = 0; i < 3; i++) begin
            el[i] = use_m[i] ? m_len(f, r[i]) : 1;
            eb[i] = use_m[i] ? m_bw(f, r[i]) : 0;
            ev[i] = use_m[i] && m_mark(f, r[i]);
            if (use_m[i] && el[i] > 1) any_long = 1;
            if (use_m[i] && eb[i] != 0) any_pk = 1;
            chk({req, " len R3"}, int'(op_len[i*LEN_W +: LEN_W]), el[i]);
            chk({req, " bw R4"}, int'(op_bw[i*2 +: 2]), eb[i]);
            chk({req, " vec R2"}, int'(op_vec[i]), int'(ev[i]));
        end
        if (el[1] > 1 && el[2] > 1 && el[1] != el[2]) flt = 1;             // R8
        if (el[0] > 1 && (el[1] > el[0] || el[2] > el[0])) flt = 1;        // R9
        chk({req, " passthru R6"}, int'(mode_passthru), int'(!any_long && !any_pk));
        chk({req, " vector R7"}, int'(mode_vector), int'(any_long));
        chk({req, " packed R7"}, int'(mode_packed), int'(any_pk));
        chk({req, " fault R8 R9"}, int'(len_fault), int'(flt));
    endtask

    task automatic sweep8(string req);
        for (int f = 0; f < 2; f++)
            for (int u = 0; u < 8; u++)
                for (int d = 0; d < 8; d++)
                    for (int a = 0; a < 8; a++)
                        for (int b = 0; b < 8; b++)
                            look(f[0], u[2:0], d, a, b, req);
    endtask

    initial begin
        for (int e = 0; e < NENT; e++) begin
            m_ev[e] = 0; m_ef[e] = 0; m_er[e] = 0; m_eb[e] = 0; m_el[e] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < NREG; r++) begin
            look(r[0], 3'b111, r, (r + 1) % NREG, (r + 7) % NREG, "reset R1");
        end

        // R11: write timing for the integer bitmap
        @(negedge clk);
        csr_we = 1'b1; csr_kind = 2'd0; csr_wdata = 32'h0000_0008;
        op_file = 1'b0; op_use = 3'b001; op_reg = {5'd0, 5'd0, 5'd3};
        #1 chk("before edge R11", int'(op_vec[0]), 0);
        @(posedge clk); #1;
        chk("after edge R11", int'(op_vec[0]), 1);
        @(negedge clk); csr_we = 1'b0; m_imap = 32'h0000_0008;

        // Full register sweep with mixed bitmaps and a split-file table
        wr_map(0, 32'hA5C3_0F96);
        wr_map(1, 32'h3C5A_F00F);
        wr_ent(0, 1, 0, 2, 1, 4);
        wr_ent(1, 1, 1, 2, 2, 9);
        for (int f = 0; f < 2; f++)
            for (int r = 0; r < NREG; r++)
                look(f[0], 3'b001, r, 0, 0, "regsweep R2 R5");

        // Phase A: two integer entries of different lengths
        wr_map(0, 32'h0000_00EE);
        wr_map(1, 32'h0000_0068);
        wr_ent(0, 1, 0, 3, 0, 4);
        wr_ent(1, 1, 0, 5, 1, 8);
        sweep8("phaseA R8 R9 R10");

        // Phase B: same register number in both files
        wr_ent(0, 1, 0, 3, 3, 4);
        wr_ent(1, 1, 1, 3, 2, 2);
        sweep8("phaseB R5 R7");

        // Priority: both entries on integer register 6
        wr_ent(0, 1, 0, 6, 1, 3);
        wr_ent(1, 1, 0, 6, 2, 5);
        look(0, 3'b001, 6, 0, 0, "priority R3");
        chk("priority len R3", int'(op_len[7:0]), 3);
        wr_ent(0, 0, 0, 6, 1, 3);
        look(0, 3'b001, 6, 0, 0, "fallthrough R3");
        chk("fallthrough len R3", int'(op_len[7:0]), 5);

        // Unmarked register with a matching entry stays scalar
        wr_map(0, 32'h0000_0000);
        look(0, 3'b111, 6, 6, 6, "unmarked R4");
        chk("unmarked len R4", int'(op_len[7:0]), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule